// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable two-wire (I2C) target that fronts a 4096 x 8 byte array. It runs on a fast system clock and sees the bus only through two synchronized, deglitched copies of SCL and SDA. From these it detects START and STOP conditions and shifts bits on the filtered clock edges. It drives SDA through a single open-drain pull-down output.

A controller selects the device with a 7-bit address. The upper four bits of that address are fixed and the lower three come from strap pins. After the address, the controller sends a 12-bit word address in two bytes. It can then write one byte or a run of bytes within a 32-byte page. It can also read from the current address, read from an address it has just set with a dummy write, or read many bytes in sequence.

Written bytes collect in a page buffer and reach the array only when a STOP closes the write. A timed program window follows. During that window the device stays silent on the bus. A write-protect input vetoes individual data bytes.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A level on SCL or SDA that persists for fewer than FILT_CYCLES consecutive system clocks is ignored, so it is not seen as a clock edge, START or STOP.
- R2: The block acknowledges an address byte only when its upper seven bits equal binary 1010 followed by strap_i[2:0]. Bit 0 of that byte selects a read when it is 1. For any other address byte, SDA stays released and the block ignores the bus until the next START.
- R3: The first word-address byte supplies address bits 11..8 from its low four bits, and its upper four bits are ignored. The second byte supplies bits 7..0.
- R4: Each address byte and each data byte of a write is acknowledged, and the data reaches the array only after a STOP.
- R5: During a write, the low five address bits advance after every data byte and wrap within the same 32-byte page. A byte past the 32nd therefore replaces an earlier byte of that page.
- R6: A STOP that ends a write which buffered at least one byte starts a program window of WRITE_CYCLES system clocks. Throughout that window the block acknowledges no address and never pulls SDA.
- R7: A data byte for which wp_i is high at the rising SCL edge of its acknowledge clock is still acknowledged but is not stored, and the address still advances. If no byte of a write was stored, the STOP starts no program window.
- R8: A read that starts without a word address returns the byte at the address that follows the last byte read or written.
- R9: A dummy write of the word address, followed by a repeated START and a read address, returns the byte at that word address and changes no stored data.
- R10: While the controller acknowledges each byte, a read continues at the next address, incrementing all 12 bits and wrapping from 0xFFF to 0x000. A NACK from the controller ends the read with SDA released.
- R11: After reset, SDA is released and the block is not in a program window.
- R12: A START that comes before the STOP of a write discards every byte buffered by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| strap_i | input | 3 | Strap pins that set the low three address bits |
| wp_i | input | 1 | Write protect; high blocks the storing of data bytes |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The end of the program window can fall in the same cycle as the start of an address byte from a controller that polls for readiness. The bench provokes this by issuing START plus address repeatedly right after the STOP of a write, closing every unacknowledged attempt with a STOP. It judges the result by requiring that the first acknowledged attempt completes no sooner than WRITE_CYCLES clocks after that STOP and no later than one extra polling attempt beyond it. A read that follows must return the newly stored byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/eeprom_line_filter.sv
module eeprom_line_filter #(
  parameter int FILT_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_CYCLES - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = out_q;

  // R1: the filtered level moves only once the new level has lasted the full window
  a_r1_change_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(cnt_q) == CW'(FILT_CYCLES - 1)));
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [PAGE_W-1:0]        wr_idx_i,
  input  logic [7:0]               wr_data_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [7:0]               mem [DEPTH];
  logic [7:0]               pbuf [PAGE];
  logic [PAGE-1:0]          valid_q;
  logic [ADDR_W-PAGE_W-1:0] base_q;
  logic                     busy_q;
  logic [TW-1:0]            tcnt_q;
  logic [PAGE_W-1:0]        idx;
  logic                     mem_we;

  assign idx    = tcnt_q[PAGE_W-1:0];
  assign mem_we = busy_q && (tcnt_q < TW'(PAGE)) && valid_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      base_q  <= '0;
      busy_q  <= 1'b0;
      tcnt_q  <= '0;
    end else if (busy_q) begin
      if (tcnt_q == TW'(WRITE_CYCLES - 1)) begin
        busy_q  <= 1'b0;
        valid_q <= '0;
        tcnt_q  <= '0;
      end else begin
        tcnt_q <= tcnt_q + TW'(1);
      end
    end else if (commit_i && (|valid_q)) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
      base_q <= base_i;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (wr_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !busy_q) pbuf[wr_idx_i] <= wr_data_i;
  end

  // program one buffered byte per cycle at the head of the window
  always_ff @(posedge clk_i) begin
    if (mem_we) mem[{base_q, idx}] <= pbuf[idx];
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy_q;

  // R6: window never outlives its length
  a_r6_window_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (tcnt_q < TW'(WRITE_CYCLES)));
  // R6: a commit with buffered bytes opens the window
  a_r6_commit_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_q && (|valid_q)) |=> busy_q);
  // R12: a clear request empties the buffer
  a_r12_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !busy_q && !commit_i) |=> (valid_q == '0));
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_W       = 5,
  parameter int FILT_CYCLES  = 5,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    eeprom_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  assign scl_f     = filt[1];
  assign sda_f     = filt[0];
  assign start_det = scl_f && scl_q && sda_q && !sda_f;
  assign stop_det  = scl_f && scl_q && !sda_q && sda_f;
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;

  bus_st_e           st_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q;
  logic              ack_ph_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pull_q;
  logic              busy;
  logic [7:0]        rd_data;
  logic              buf_wr;
  logic              dev_hit;

  assign dev_hit = (sh_q[7:1] == {DEV_CODE, strap_i});
  assign buf_wr  = (st_q == ST_WDAT) && ack_ph_q && scl_rise && !wp_i;

  eeprom_store #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_det),
    .wr_i      (buf_wr),
    .wr_idx_i  (addr_q[PAGE_W-1:0]),
    .wr_data_i (sh_q),
    .base_i    (addr_q[ADDR_W-1:PAGE_W]),
    .commit_i  (stop_det),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      ack_ph_q  <= 1'b0;
      addr_q    <= '0;
      pull_q    <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (busy) begin
        st_q     <= ST_IDLE;
        pull_q   <= 1'b0;
        ack_ph_q <= 1'b0;
      end else if (start_det) begin
        st_q      <= ST_DEV;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        pull_q    <= 1'b0;
      end else if (stop_det) begin
        st_q     <= ST_IDLE;
        pull_q   <= 1'b0;
        ack_ph_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: ;
          ST_RDAT: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                pull_q <= 1'b0;
                st_q   <= ST_RACK;
                addr_q <= addr_q + ADDR_ONE;
              end else begin
                sh_q   <= {sh_q[6:0], 1'b0};
                pull_q <= !sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              ack_ph_q <= !sda_f;
            end else if (scl_fall) begin
              ack_ph_q <= 1'b0;
              if (ack_ph_q) begin
                sh_q      <= rd_data;
                pull_q    <= !rd_data[7];
                bit_cnt_q <= '0;
                st_q      <= ST_RDAT;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: begin
            if (scl_rise && !ack_ph_q) begin
              sh_q      <= {sh_q[6:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_rise && ack_ph_q && (st_q == ST_WDAT)) begin
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
            end else if (scl_fall && !ack_ph_q && (bit_cnt_q == 4'd8)) begin
              bit_cnt_q <= '0;
              if ((st_q != ST_DEV) || dev_hit) begin
                pull_q   <= 1'b1;
                ack_ph_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
              if (st_q == ST_AHI) addr_q[ADDR_W-1:8] <= sh_q[ADDR_W-9:0];
              if (st_q == ST_ALO) addr_q[7:0] <= sh_q;
            end else if (scl_fall && ack_ph_q) begin
              ack_ph_q <= 1'b0;
              pull_q   <= 1'b0;
              case (st_q)
                ST_DEV: begin
                  if (sh_q[0]) begin
                    st_q   <= ST_RDAT;
                    sh_q   <= rd_data;
                    pull_q <= !rd_data[7];
                  end else begin
                    st_q <= ST_AHI;
                  end
                end
                ST_AHI:  st_q <= ST_ALO;
                ST_ALO:  st_q <= ST_WDAT;
                default: st_q <= st_q;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R6: silent on the bus during the program window
  a_r6_quiet_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_pull_o);
  // R10: SDA released while the controller answers a read byte
  a_r10_release_in_rack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACK) |-> !pull_q);
  // R2: byte framing never runs past nine bits
  a_r2_bit_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd8);
  // R5: a write burst stays inside its page
  a_r5_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WDAT) && ($past(st_q) == ST_WDAT)) |->
      (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));
endmodule

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;
  localparam int Q     = 10;
  localparam int WCYC  = 1500;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;

  logic [7:0] model [4096];
  logic [7:0] exp_q [$];
  logic [7:0] obs_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign sda_line = sda_m & ~sda_pull;

  eeprom_i2c_target #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (STRAP),
    .wp_i       (wp),
    .sda_pull_o (sda_pull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] o, e;
      string t;
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(o === e, t, int'(o), int'(e));
    end
  end

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  // mode 1: short SCL spike in the low phase; mode 2: short SDA dip while SCL is high
  task automatic put_bit(input logic b, input int mode);
    sda_m = b;
    if (mode == 1) begin
      tick(Q / 2); scl_m = 1'b1; tick(3); scl_m = 1'b0; tick(Q - Q / 2 - 3);
    end else begin
      tick(Q);
    end
    scl_m = 1'b1;
    if (mode == 2) begin
      tick(Q / 2); sda_m = 1'b0; tick(3); sda_m = b; tick(2 * Q - Q / 2 - 3);
    end else begin
      tick(2 * Q);
    end
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], 0);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!ack_it, 0);
  endtask

  task automatic poll_ready(output int waited);
    bit ack;
    int t0;
    t0 = cyc;
    ack = 1'b0;
    while (!ack) begin
      i2c_start();
      send_byte(DEV_W, ack);
      i2c_stop();
    end
    waited = cyc - t0;
  endtask

  task automatic wr_seq(input int a, input int n, input logic [7:0] v0, input string tag);
    bit ack;
    int w;
    i2c_start();
    send_byte(DEV_W, ack);               chk(ack, tag, ack, 1);
    send_byte(8'(a >> 8), ack);          chk(ack, tag, ack, 1);
    send_byte(8'(a), ack);               chk(ack, tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(v0 + 8'(i), ack);
      chk(ack, tag, ack, 1);
      if (!wp) model[(a & 12'hFE0) | ((a + i) & 31)] = v0 + 8'(i);
    end
    i2c_stop();
    poll_ready(w);
  endtask

  task automatic rd_burst(input int a, input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(a + i) & 12'hFFF]);
      tag_q.push_back(tag);
      recv_byte(d, i < n - 1);
      obs_q.push_back(d);
    end
  endtask

  task automatic rand_read(input int a, input int n, input string tag);
    bit ack;
    i2c_start();
    send_byte(DEV_W, ack);               chk(ack, tag, ack, 1);
    send_byte(8'(a >> 8), ack);          chk(ack, tag, ack, 1);
    send_byte(8'(a), ack);               chk(ack, tag, ack, 1);
    i2c_start();
    send_byte(DEV_R, ack);               chk(ack, tag, ack, 1);
    rd_burst(a, n, tag);
    i2c_stop();
  endtask

  initial begin
    bit ack;
    int w, t0, t1;
    logic [7:0] d;

    tick(5);
    chk(sda_pull == 1'b0, "R11 sda in reset", sda_pull, 0);
    rst_n = 1'b1;
    tick(20);
    chk(sda_pull == 1'b0, "R11 sda after reset", sda_pull, 0);

    // R2: strap mismatch and wrong fixed code
    i2c_start(); send_byte({4'b1010, 3'b100, 1'b0}, ack); i2c_stop();
    chk(!ack, "R2 strap mismatch", ack, 0);
    i2c_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); i2c_stop();
    chk(!ack, "R2 code mismatch", ack, 0);
    i2c_start(); send_byte(DEV_W, ack); i2c_stop();
    chk(ack, "R11 R2 idle device acks", ack, 1);

    // R4 R6: byte write, program window timing
    i2c_start();
    send_byte(DEV_W, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    send_byte(8'h5A, ack);
    chk(ack, "R4 data ack", ack, 1);
    i2c_stop();
    t0 = cyc;
    model[12'h123] = 8'h5A;
    i2c_start(); send_byte(DEV_W, ack); i2c_stop();
    chk(!ack, "R6 no ack in window", ack, 0);
    poll_ready(w);
    t1 = cyc;
    chk((t1 - t0) >= WCYC, "R6 window length", t1 - t0, WCYC);
    chk((t1 - t0) <= WCYC + 1200, "R6 window ends", t1 - t0, WCYC + 1200);
    rand_read(12'h123, 1, "R4 R9 byte readback");

    // R3: upper nibble of first address byte ignored
    i2c_start();
    send_byte(DEV_W, ack); send_byte(8'hF1, ack); send_byte(8'h24, ack);
    send_byte(8'h66, ack);
    i2c_stop();
    model[12'h124] = 8'h66;
    poll_ready(w);
    rand_read(12'h124, 1, "R3 high nibble ignored");

    // R5: 34-byte write from offset 0x1C wraps within page 0x2E0
    wr_seq(12'h2FC, 34, 8'h80, "R5 page write ack");
    rand_read(12'h2E0, 32, "R5 R10 page readback");

    // R8: current address read after a one-byte random read
    rand_read(12'h2E5, 1, "R8 setup read");
    i2c_start();
    send_byte(DEV_R, ack);
    chk(ack, "R8 read address ack", ack, 1);
    rd_burst(12'h2E6, 2, "R8 current address");
    i2c_stop();

    // R7: write protect blocks the byte, no program window
    wp = 1'b1;
    i2c_start();
    send_byte(DEV_W, ack); send_byte(8'h02, ack); send_byte(8'hE6, ack);
    send_byte(8'h11, ack);
    chk(ack, "R7 protected byte acked", ack, 1);
    i2c_stop();
    i2c_start(); send_byte(DEV_W, ack); i2c_stop();
    chk(ack, "R7 no window after protected write", ack, 1);
    wp = 1'b0;
    rand_read(12'h2E6, 1, "R7 protected byte unchanged");

    // R12: repeated START discards buffered data
    i2c_start();
    send_byte(DEV_W, ack); send_byte(8'h02, ack); send_byte(8'hE7, ack);
    send_byte(8'h22, ack);
    rand_read(12'h2E7, 1, "R12 R9 discarded byte");
    i2c_start(); send_byte(DEV_W, ack); i2c_stop();
    chk(ack, "R12 no window after discard", ack, 1);

    // R10: sequential read wraps 0xFFF to 0x000
    wr_seq(12'hFFE, 2, 8'hA1, "R10 setup top");
    wr_seq(12'h000, 1, 8'hA3, "R10 setup bottom");
    rand_read(12'hFFE, 3, "R10 address wrap");
    chk(sda_pull == 1'b0, "R10 released after nack", sda_pull, 0);

    // R1: short spikes on SCL and SDA during an address byte
    i2c_start();
    put_bit(DEV_W[7], 2);
    put_bit(DEV_W[6], 0);
    put_bit(DEV_W[5], 0);
    put_bit(DEV_W[4], 1);
    for (int i = 3; i >= 0; i--) put_bit(DEV_W[i], 0);
    get_bit(d[0]);
    chk(d[0] == 1'b0, "R1 spikes filtered ack", d[0], 0);
    send_byte(8'h01, ack); send_byte(8'h23, ack);
    i2c_start();
    send_byte(DEV_R, ack);
    rd_burst(12'h123, 1, "R1 aligned after spikes");
    i2c_stop();

    tick(50);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule